// File: doc/BRIEF.md
# Flash Controller with Word-Fill Erase Engine

This block sits between a 32-bit register port and a NOR-style on-chip flash array, together with a small store of user configuration words. Software sets a mode register to allow programming or erasing. Programming a flash word can only clear bits: the stored word becomes the old word ANDed with the new data. Three erase commands exist. A page erase names any byte inside a page. A full wipe clears the whole array and the user store. A user wipe clears only the user store.

Page erase and full wipe run on a fill engine that writes one word of all ones per clock. A status register shows whether that engine is idle. Flash contents and user words are read through separate combinational ports. The array size, page size, user store depth and the erase key value are parameters. This keeps a default instance small enough to be checked word by word.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, register offset 1 (mode) reads 0, register offset 0 (status) reads 1 in bit 0, and every user word reads 0xFFFFFFFF.
- R2: A write to offset 1 stores only bits [1:0] (bit 0 = program enable, bit 1 = erase enable); the upper bits read as zero and the value holds until the next write to offset 1.
- R3: A flash port write is accepted only while program enable is set and the engine is idle; the addressed word then becomes old AND data, and with program enable clear the word is unchanged.
- R4: With erase enable set, a write to offset 2 or offset 3 takes a byte address, discards its in-page low bits, and fills every word of that page with 0xFFFFFFFF, leaving words outside the page unchanged.
- R5: A page erase whose page start exceeds the array size minus one page is ignored; the highest page itself is erasable.
- R6: With erase enable set, writing the erase key (default 1) to offset 4 fills the whole array with 0xFFFFFFFF and sets every user word to 0xFFFFFFFF, the user words already in the next cycle.
- R7: Writing the erase key to offset 5 sets every user word to 0xFFFFFFFF in the next cycle whatever the mode, leaves flash untouched and does not make status busy.
- R8: With erase enable clear, page erase and full wipe do nothing; a value other than the key written to offset 4 or 5 does nothing.
- R9: After a page erase or full wipe command, status bit 0 reads 0 for exactly one page worth of words or the full array word count of cycles; while busy, flash writes and further erase commands are ignored.
- R10: Writes to offsets 6 to 15 change no state; reads of any offset other than 0 and 1 return zero.
- R11: The user port writes a whole word at the given index in one clock, and the user read port returns the stored word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Register access is a write |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| flash_we | input | 1 | Flash program strobe |
| flash_addr | input | FAW | Flash word index for program and read |
| flash_wdata | input | 32 | Flash program data |
| flash_rdata | output | 32 | Stored flash word at flash_addr |
| user_we | input | 1 | User store write strobe |
| user_addr | input | UAW | User word index |
| user_wdata | input | 32 | User store write data |
| user_rdata | output | 32 | Stored user word at user_addr |

## Verification
The bench goes after the page boundary. It erases with an address in the last byte of a page and checks the words on both sides. A design that kept the low address bits would clear part of the next page, and one with an off-by-one fill count would clip the last word. It checks the busy window by counting status cycles, and it issues a flash write and a second erase inside that window. A design that did not gate on busy would corrupt a word or erase a page it was never asked to. It also erases the highest legal page and tries the first illegal one, where a wrong bound either drops a valid erase or wraps into page zero. Last, it sends the wrong key, and a user wipe with erase disabled, to catch permission logic applied to the wrong command.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

    // Register word offsets; offsets 6..15 are unused
    typedef enum logic [3:0] {
        REG_STATUS    = 4'd0,
        REG_MODE      = 4'd1,
        REG_PAGE_A    = 4'd2,
        REG_PAGE_B    = 4'd3,
        REG_WIPE_ALL  = 4'd4,
        REG_WIPE_USER = 4'd5
    } reg_sel_e;

    // Mode register layout: bit 1 erase enable, bit 0 program enable
    typedef struct packed {
        logic erase_en;
        logic prog_en;
    } mode_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_FILL = 1'b1
    } eng_state_e;

    localparam logic [31:0] WORD_ONES = 32'hFFFF_FFFF;

    // Clear the in-page offset bits of a byte address
    function automatic logic [31:0] page_base(input logic [31:0] byte_addr,
                                              input int unsigned shift);
        logic [31:0] keep;
        keep = 32'hFFFF_FFFF << shift;
        return byte_addr & keep;
    endfunction

endpackage

// File: rtl/nvm_regfile.sv
module nvm_regfile
    import nvm_ctrl_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 1024,
    parameter int unsigned PAGE_BYTES  = 256,
    parameter int unsigned FAW         = 8,
    parameter logic [31:0] ERASE_KEY   = 32'h1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_valid,
    input  logic           reg_write,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    input  logic           busy,
    output logic [31:0]    reg_rdata,
    output mode_t          mode,
    output logic           cmd_go,
    output logic [FAW-1:0] cmd_first,
    output logic [FAW-1:0] cmd_last,
    output logic           user_clear
);
    localparam int unsigned PAGE_SHIFT  = $clog2(PAGE_BYTES);
    localparam int unsigned PAGE_WORDS  = PAGE_BYTES / 4;
    localparam int unsigned FLASH_WORDS = FLASH_BYTES / 4;
    localparam logic [31:0] LAST_BASE   = 32'(FLASH_BYTES - PAGE_BYTES);

    reg_sel_e    sel;
    logic        wr;
    logic        key_ok;
    logic [31:0] base;
    logic        page_hit;
    logic        all_hit;
    logic        user_hit;

    assign sel    = reg_sel_e'(reg_addr);
    assign wr     = reg_valid & reg_write;
    assign key_ok = (reg_wdata == ERASE_KEY);
    assign base   = page_base(reg_wdata, PAGE_SHIFT);

    assign page_hit = wr && !busy && mode.erase_en &&
                      (sel == REG_PAGE_A || sel == REG_PAGE_B) &&
                      (base <= LAST_BASE);
    assign all_hit  = wr && !busy && mode.erase_en && key_ok &&
                      (sel == REG_WIPE_ALL);
    assign user_hit = wr && !busy && key_ok && (sel == REG_WIPE_USER);

    assign cmd_go     = page_hit | all_hit;
    assign user_clear = user_hit | all_hit;

    always_comb begin
        if (page_hit) begin
            cmd_first = base[FAW+1:2];
            cmd_last  = base[FAW+1:2] + FAW'(PAGE_WORDS - 1);
        end else begin
            cmd_first = '0;
            cmd_last  = FAW'(FLASH_WORDS - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr && sel == REG_MODE) begin
            mode <= mode_t'(reg_wdata[1:0]);
        end
    end

    always_comb begin
        case (sel)
            REG_STATUS: reg_rdata = {31'b0, ~busy};
            REG_MODE:   reg_rdata = {30'b0, mode};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nvm_fill_engine.sv
module nvm_fill_engine
    import nvm_ctrl_pkg::*;
#(
    parameter int unsigned FAW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_go,
    input  logic [FAW-1:0] cmd_first,
    input  logic [FAW-1:0] cmd_last,
    output logic           busy,
    output logic           fill_en,
    output logic [FAW-1:0] fill_addr
);
    localparam logic [FAW-1:0] STEP = FAW'(1);

    eng_state_e     state;
    logic [FAW-1:0] ptr;
    logic [FAW-1:0] stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            ptr   <= '0;
            stop  <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (cmd_go) begin
                        state <= ENG_FILL;
                        ptr   <= cmd_first;
                        stop  <= cmd_last;
                    end
                end
                ENG_FILL: begin
                    if (ptr == stop) begin
                        state <= ENG_IDLE;
                    end else begin
                        ptr <= ptr + STEP;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy      = (state == ENG_FILL);
    assign fill_en   = busy;
    assign fill_addr = ptr;

endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_ctrl_pkg::*;
#(
    parameter int unsigned FLASH_WORDS = 256,
    parameter int unsigned USER_WORDS  = 8,
    parameter int unsigned FAW         = 8,
    parameter int unsigned UAW         = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prog_ok,
    input  logic [FAW-1:0] flash_addr,
    input  logic [31:0]    flash_wdata,
    output logic [31:0]    flash_rdata,
    input  logic           fill_en,
    input  logic [FAW-1:0] fill_addr,
    input  logic           user_we,
    input  logic [UAW-1:0] user_addr,
    input  logic [31:0]    user_wdata,
    input  logic           user_clear,
    output logic [31:0]    user_rdata
);
    logic [31:0] flash_mem [FLASH_WORDS];
    logic [31:0] user_mem  [USER_WORDS];

    // Flash array keeps its contents across reset
    always_ff @(posedge clk) begin
        if (fill_en) begin
            flash_mem[fill_addr] <= WORD_ONES;
        end else if (prog_ok) begin
            flash_mem[flash_addr] <= flash_mem[flash_addr] & flash_wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < USER_WORDS; i++) begin
            if (rst || user_clear) begin
                user_mem[i] <= WORD_ONES;
            end else if (user_we && user_addr == UAW'(i)) begin
                user_mem[i] <= user_wdata;
            end
        end
    end

    assign flash_rdata = flash_mem[flash_addr];
    assign user_rdata  = user_mem[user_addr];

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_ctrl_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 1024,
    parameter int unsigned PAGE_BYTES  = 256,
    parameter int unsigned USER_WORDS  = 8,
    parameter logic [31:0] ERASE_KEY   = 32'h1,
    localparam int unsigned FLASH_WORDS = FLASH_BYTES / 4,
    localparam int unsigned FAW         = $clog2(FLASH_WORDS),
    localparam int unsigned UAW         = $clog2(USER_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_valid,
    input  logic           reg_write,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           flash_we,
    input  logic [FAW-1:0] flash_addr,
    input  logic [31:0]    flash_wdata,
    output logic [31:0]    flash_rdata,
    input  logic           user_we,
    input  logic [UAW-1:0] user_addr,
    input  logic [31:0]    user_wdata,
    output logic [31:0]    user_rdata
);
    mode_t          mode;
    logic           busy;
    logic           cmd_go;
    logic [FAW-1:0] cmd_first;
    logic [FAW-1:0] cmd_last;
    logic           user_clear;
    logic           fill_en;
    logic [FAW-1:0] fill_addr;
    logic           prog_ok;

    assign prog_ok = flash_we & mode.prog_en & ~busy;

    nvm_regfile #(
        .FLASH_BYTES (FLASH_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .FAW         (FAW),
        .ERASE_KEY   (ERASE_KEY)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .reg_rdata  (reg_rdata),
        .mode       (mode),
        .cmd_go     (cmd_go),
        .cmd_first  (cmd_first),
        .cmd_last   (cmd_last),
        .user_clear (user_clear)
    );

    nvm_fill_engine #(
        .FAW (FAW)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .cmd_go    (cmd_go),
        .cmd_first (cmd_first),
        .cmd_last  (cmd_last),
        .busy      (busy),
        .fill_en   (fill_en),
        .fill_addr (fill_addr)
    );

    nvm_store #(
        .FLASH_WORDS (FLASH_WORDS),
        .USER_WORDS  (USER_WORDS),
        .FAW         (FAW),
        .UAW         (UAW)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .prog_ok     (prog_ok),
        .flash_addr  (flash_addr),
        .flash_wdata (flash_wdata),
        .flash_rdata (flash_rdata),
        .fill_en     (fill_en),
        .fill_addr   (fill_addr),
        .user_we     (user_we),
        .user_addr   (user_addr),
        .user_wdata  (user_wdata),
        .user_clear  (user_clear),
        .user_rdata  (user_rdata)
    );

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
    parameter int unsigned FAW       = 8,
    parameter int unsigned UAW       = 3,
    parameter logic [31:0] ERASE_KEY = 32'h1
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_valid,
    input logic           reg_write,
    input logic [3:0]     reg_addr,
    input logic [31:0]    reg_wdata,
    input logic [31:0]    reg_rdata,
    input logic           flash_we,
    input logic [FAW-1:0] flash_addr,
    input logic [31:0]    flash_wdata,
    input logic [31:0]    flash_rdata,
    input logic [UAW-1:0] user_addr,
    input logic [31:0]    user_rdata,
    input logic [1:0]     mode,
    input logic           busy,
    input logic [FAW-1:0] fill_addr
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && mode == 2'b00)); // R1

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_valid && reg_write && reg_addr == 4'd1) |-> $stable(mode)); // R2

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(reg_valid && reg_write && reg_addr == 4'd1 && !rst)
        |-> mode == $past(reg_wdata[1:0])); // R2

    AST_PROG_AND: assert property (@(posedge clk) disable iff (rst)
        ($past(flash_we && mode[0] && !busy && !rst) && $stable(flash_addr))
        |-> flash_rdata == ($past(flash_rdata) & $past(flash_wdata))); // R3

    AST_FILL_ONES: assert property (@(posedge clk) disable iff (rst)
        ($past(busy && !rst) && $past(fill_addr) == flash_addr)
        |-> flash_rdata == 32'hFFFF_FFFF); // R4

    AST_USER_WIPE: assert property (@(posedge clk) disable iff (rst)
        $past(reg_valid && reg_write && reg_addr == 4'd5 &&
              reg_wdata == ERASE_KEY && !busy && !rst)
        |-> user_rdata == 32'hFFFF_FFFF); // R7

    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_addr == 4'd0) |-> reg_rdata[0] == 1'b0); // R9

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > 4'd1) |-> reg_rdata == 32'h0); // R10

endmodule

bind nvm_ctrl nvm_ctrl_chk #(
    .FAW       (FAW),
    .UAW       (UAW),
    .ERASE_KEY (ERASE_KEY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_valid   (reg_valid),
    .reg_write   (reg_write),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .flash_we    (flash_we),
    .flash_addr  (flash_addr),
    .flash_wdata (flash_wdata),
    .flash_rdata (flash_rdata),
    .user_addr   (user_addr),
    .user_rdata  (user_rdata),
    .mode        (mode),
    .busy        (busy),
    .fill_addr   (fill_addr)
);

// File: tb/nvm_ctrl_test.sv
`timescale 1ns/1ps
module nvm_ctrl_test;
    localparam int FW = 256;
    localparam int PW = 64;
    localparam int UW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flash_we = 1'b0;
    logic [7:0]  flash_addr = '0;
    logic [31:0] flash_wdata = '0;
    logic [31:0] flash_rdata;
    logic        user_we = 1'b0;
    logic [2:0]  user_addr = '0;
    logic [31:0] user_wdata = '0;
    logic [31:0] user_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nvm_ctrl uut (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flash_we(flash_we), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
        .flash_rdata(flash_rdata),
        .user_we(user_we), .user_addr(user_addr), .user_wdata(user_wdata),
        .user_rdata(user_rdata)
    );

    // {word index, first data, second data, expected word}
    localparam logic [103:0] PROG_VEC [5] = '{
        {8'd1,   32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000},
        {8'd2,   32'h12345678, 32'hFFFFFFFF, 32'h12345678},
        {8'd3,   32'hAAAAAAAA, 32'h55555555, 32'h00000000},
        {8'd4,   32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {8'd255, 32'h80000001, 32'hF000000F, 32'h80000001}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic flash_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        flash_we = 1'b1; flash_addr = a; flash_wdata = d;
        @(negedge clk);
        flash_we = 1'b0;
    endtask

    task automatic flash_rd(input logic [7:0] a, output logic [31:0] d);
        flash_addr = a;
        #1;
        d = flash_rdata;
    endtask

    task automatic user_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        user_we = 1'b1; user_addr = a; user_wdata = d;
        @(negedge clk);
        user_we = 1'b0;
    endtask

    task automatic user_rd(input logic [2:0] a, output logic [31:0] d);
        user_addr = a;
        #1;
        d = user_rdata;
    endtask

    // Count cycles with status bit 0 low, starting just after a command
    task automatic busy_count(output int n);
        n = 0;
        reg_addr = 4'd0;
        #1;
        while (reg_rdata[0] == 1'b0 && n < 5000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic print_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        print_summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        bit ok;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_rd(4'd1, v);
        check(v == 32'h0, "R1 mode after reset", v, 32'h0);
        reg_rd(4'd0, v);
        check(v == 32'h1, "R1 status after reset", v, 32'h1);
        ok = 1'b1;
        for (int i = 0; i < UW; i++) begin
            user_rd(3'(i), v);
            if (v != 32'hFFFFFFFF) ok = 1'b0;
        end
        check(ok, "R1 user words after reset", {31'b0, ok}, 32'h1);

        // R8 full wipe with erase disabled
        reg_wr(4'd4, 32'h1);
        reg_rd(4'd0, v);
        check(v == 32'h1, "R8 wipe-all ignored when erase disabled", v, 32'h1);

        // R6 / R9 full wipe
        reg_wr(4'd1, 32'h2);
        reg_wr(4'd4, 32'h1);
        busy_count(n);
        check(n == FW, "R9 busy cycles for full wipe", 32'(n), 32'(FW));
        ok = 1'b1;
        for (int i = 0; i < FW; i++) begin
            flash_rd(8'(i), v);
            if (v != 32'hFFFFFFFF) ok = 1'b0;
        end
        check(ok, "R6 whole array ones after wipe", {31'b0, ok}, 32'h1);

        // R2 mode masking
        reg_wr(4'd1, 32'hFFFFFFFF);
        reg_rd(4'd1, v);
        check(v == 32'h3, "R2 mode keeps two bits", v, 32'h3);

        // R3 table walk of programming vectors
        reg_wr(4'd1, 32'h1);
        for (int k = 0; k < 5; k++) begin
            flash_wr(PROG_VEC[k][103:96], PROG_VEC[k][95:64]);
            flash_wr(PROG_VEC[k][103:96], PROG_VEC[k][63:32]);
            flash_rd(PROG_VEC[k][103:96], v);
            check(v == PROG_VEC[k][31:0], "R3 program clears bits only", v, PROG_VEC[k][31:0]);
        end

        // R3 program disabled
        reg_wr(4'd1, 32'h0);
        flash_wr(8'd10, 32'h0);
        flash_rd(8'd10, v);
        check(v == 32'hFFFFFFFF, "R3 write ignored without program enable", v, 32'hFFFFFFFF);

        // Prepare words around page 1 and in page 3
        reg_wr(4'd1, 32'h1);
        flash_wr(8'd63, 32'h0);
        flash_wr(8'd64, 32'h0);
        flash_wr(8'd127, 32'h0);
        flash_wr(8'd128, 32'h0);
        flash_wr(8'd200, 32'h0);

        // R4 page erase with in-page offset
        reg_wr(4'd1, 32'h3);
        reg_wr(4'd2, 32'h000001FC);
        busy_count(n);
        check(n == PW, "R9 busy cycles for page erase", 32'(n), 32'(PW));
        flash_rd(8'd64, v);
        check(v == 32'hFFFFFFFF, "R4 first word of page erased", v, 32'hFFFFFFFF);
        flash_rd(8'd127, v);
        check(v == 32'hFFFFFFFF, "R4 last word of page erased", v, 32'hFFFFFFFF);
        flash_rd(8'd63, v);
        check(v == 32'h0, "R4 word below page kept", v, 32'h0);
        flash_rd(8'd128, v);
        check(v == 32'h0, "R4 word above page kept", v, 32'h0);

        // R9 activity while busy is ignored
        reg_wr(4'd3, 32'h00000100);
        flash_wr(8'd0, 32'h0);
        reg_wr(4'd2, 32'h00000300);
        busy_count(n);
        flash_rd(8'd0, v);
        check(v == 32'hFFFFFFFF, "R9 flash write ignored while busy", v, 32'hFFFFFFFF);
        flash_rd(8'd200, v);
        check(v == 32'h0, "R9 erase ignored while busy", v, 32'h0);

        // R5 page beyond the array
        reg_wr(4'd2, 32'h00000400);
        reg_rd(4'd0, v);
        check(v == 32'h1, "R5 out-of-range erase not started", v, 32'h1);
        flash_rd(8'd200, v);
        check(v == 32'h0, "R5 out-of-range erase changes nothing", v, 32'h0);

        // R5 highest page is erasable
        reg_wr(4'd2, 32'h000003FF);
        busy_count(n);
        flash_rd(8'd200, v);
        check(v == 32'hFFFFFFFF, "R5 last page erased", v, 32'hFFFFFFFF);
        flash_rd(8'd128, v);
        check(v == 32'h0, "R5 page below last kept", v, 32'h0);

        // R8 page erase with erase disabled
        reg_wr(4'd1, 32'h1);
        reg_wr(4'd2, 32'h00000000);
        reg_rd(4'd0, v);
        check(v == 32'h1, "R8 page erase not started when disabled", v, 32'h1);
        flash_rd(8'd63, v);
        check(v == 32'h0, "R8 page erase ignored when disabled", v, 32'h0);

        // R11 user port
        user_wr(3'd3, 32'h12345678);
        user_rd(3'd3, v);
        check(v == 32'h12345678, "R11 user word write", v, 32'h12345678);
        user_rd(3'd4, v);
        check(v == 32'hFFFFFFFF, "R11 other user word untouched", v, 32'hFFFFFFFF);

        // R8 wrong key
        reg_wr(4'd5, 32'h2);
        user_rd(3'd3, v);
        check(v == 32'h12345678, "R8 wrong key ignored", v, 32'h12345678);

        // R7 user wipe with erase disabled
        reg_wr(4'd1, 32'h0);
        reg_wr(4'd5, 32'h1);
        reg_rd(4'd0, v);
        check(v == 32'h1, "R7 user wipe not busy", v, 32'h1);
        user_rd(3'd3, v);
        check(v == 32'hFFFFFFFF, "R7 user wipe clears word", v, 32'hFFFFFFFF);
        flash_rd(8'd63, v);
        check(v == 32'h0, "R7 user wipe leaves flash", v, 32'h0);

        // R6 full wipe clears user store
        user_wr(3'd2, 32'h0);
        reg_wr(4'd1, 32'h2);
        reg_wr(4'd4, 32'h1);
        user_rd(3'd2, v);
        check(v == 32'hFFFFFFFF, "R6 wipe-all clears user word", v, 32'hFFFFFFFF);
        busy_count(n);
        flash_rd(8'd63, v);
        check(v == 32'hFFFFFFFF, "R6 wipe-all clears flash word", v, 32'hFFFFFFFF);

        // R10 undefined offsets
        reg_wr(4'd1, 32'h1);
        reg_wr(4'd9, 32'h0);
        reg_wr(4'd6, 32'h3);
        reg_rd(4'd1, v);
        check(v == 32'h1, "R10 undefined writes keep mode", v, 32'h1);
        reg_rd(4'd9, v);
        check(v == 32'h0, "R10 undefined read zero", v, 32'h0);
        reg_rd(4'd2, v);
        check(v == 32'h0, "R10 erase register reads zero", v, 32'h0);

        print_summary();
        $finish;
    end

endmodule